// File: doc/BRIEF.md
# Two-Bit Multiplexed Host Bus Target

This block is the target end of a narrow host port whose address, command and data all travel two bits at a time. A transfer opens with a command byte sent over four clocks while the master holds its control strobe high. The target checks a device-select code in the top two bits of that byte. For register transfers it then takes an address byte, again in four two-bit slices. The low nibble of the command picks one of two 256-byte register banks, and the address byte picks the location within that bank. FIFO transfers have no address byte. Their nibble picks one of two status bytes or the next data byte of a FIFO that sits behind the block.

After the address, the block waits one decode clock and then a four-clock retry phase. In the second clock of the retry phase it makes one of three choices. It can assert stop to end the transfer with no data. It can pull its active-low ready line low, so that a data phase follows. Or it can leave ready high, so that a wait phase is inserted. Every phase after decode is four clocks long, one per two-bit slice. On reads the block drives the bus from the start of the retry phase to the end of the data phase. It then releases the bus for one turnaround clock.

The FIFO side is a valid/ready stream. The FIFO raises valid while it holds a byte and keeps that byte steady until the block accepts it. A byte is taken only in the clock where valid and ready are both high, so the FIFO cannot be popped while it is empty. The status bytes are plain inputs.

Top module: `hbus2_slave`

## Requirements
- R1: A transfer starts when ctl_i is high while the block is idle. The command byte arrives in four clocks, bits [7:6] first. Only a byte whose bits [7:6] are 01 selects the block. Any other value leaves rdy_n_o high, stop_o low, had_oe_o low and fifo_ready_o low until the next command.
- R2: Command bit 5 set means read and bit 4 set means FIFO. For a register transfer, the four clocks after the command carry the address byte, bits [7:6] first. Nibble 0 (command bits [3:0]) selects the configuration bank and nibble 1 selects the general bank. Reads of any other nibble return 0, and writes to any other nibble change nothing.
- R3: One decode clock follows the last address or command clock, and in it rdy_n_o is high and had_oe_o is low. A four-clock retry phase comes next. The decision appears in its second clock: rdy_n_o low there means a data phase follows this phase.
- R4: If stall_i is high in the second retry clock of a register transfer, the block inserts exactly one four-clock wait phase and pulls rdy_n_o low in the second clock of that wait phase. stall_i has no effect on FIFO transfers.
- R5: A FIFO data read (nibble 4) with fifo_valid_i low in the second retry clock raises stop_o in that clock. No data phase follows and no byte is popped.
- R6: FIFO reads return status input 0 for nibble 0, status input 1 for nibble 1, the FIFO byte for nibble 4, and 0 for any other nibble. A nibble-4 read pops exactly one byte, with fifo_ready_o high in the last clock before the data phase.
- R7: During a read, had_oe_o is high through the retry, wait and data phases. The data phase drives the byte bits [7:6] first. The clock after the last read clock is a turnaround clock with had_oe_o low. had_oe_o stays low for writes.
- R8: A register write is committed only when all four slices of the data byte have arrived. A later read of the same location returns the whole byte.
- R9: After reset, rdy_n_o is high, stop_o, had_oe_o and fifo_ready_o are low, and every register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_i | input | 1 | Master control strobe, high during the command phase |
| had_i | input | 2 | Two-bit bus from the master |
| had_o | output | 2 | Two-bit read data to the master |
| had_oe_o | output | 1 | Enables the target's drive of the bus |
| rdy_n_o | output | 1 | Active-low ready: next phase transfers data |
| stop_o | output | 1 | Ends the transfer with no data (retry) |
| stall_i | input | 1 | Test control that asks for one wait phase on register bytes |
| fifo_valid_i | input | 1 | FIFO stream valid |
| fifo_data_i | input | 8 | FIFO stream data |
| fifo_ready_o | output | 1 | FIFO stream ready (pop) |
| fifo_stat0_i | input | 8 | FIFO status byte 0 |
| fifo_stat1_i | input | 8 | FIFO status byte 1 |

## Verification
Count clocks from the first command clock as clock 0. For a register transfer, decode falls in clock 8 and the ready/stop decision in clock 10. For a FIFO transfer they fall in clocks 4 and 6. The data phase starts four clocks after the retry phase starts, or eight clocks after it when a wait phase is inserted. The pop strobe is due in the clock just before the data phase, and the turnaround in the clock just after it. The bench advances one clock per step, drives inputs on the falling edge and samples one nanosecond later. It compares each output only in the step in which the timing above makes that output due. Expected read bytes come from a bench model of the banks and the FIFO, computed before the transfer starts.

// File: rtl/hbs_pkg.sv
`timescale 1ns/1ps
package hbs_pkg;
  localparam int SLICE_W = 2;
  localparam int BYTE_W  = 8;
  localparam int SLICES  = BYTE_W / SLICE_W;
  localparam int IDX_W   = $clog2(SLICES);

  localparam logic [1:0] DEV_CODE   = 2'b01;
  localparam logic [3:0] NIB_FSTAT0 = 4'd0;
  localparam logic [3:0] NIB_FSTAT1 = 4'd1;
  localparam logic [3:0] NIB_FDATA  = 4'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DEC, ST_RETRY, ST_WAIT, ST_DATA, ST_TA
  } phase_e;

  typedef struct packed {
    logic [1:0] dev;
    logic       rd;
    logic       fifo;
    logic [3:0] nib;
  } cmd_t;
endpackage

// File: rtl/hbs_regbank.sv
`timescale 1ns/1ps
module hbs_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/hbs_ctrl.sv
`timescale 1ns/1ps
module hbs_ctrl
  import hbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_i,
  input  logic [SLICE_W-1:0] had_i,
  input  logic               stall_i,
  input  logic               fifo_valid_i,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic [SLICE_W-1:0] had_o,
  output logic               had_oe_o,
  output logic               rdy_n_o,
  output logic               stop_o,
  output logic               fifo_ready_o,
  output cmd_t               cmd_o,
  output logic [AW-1:0]      addr_o,
  output logic               wr_en_o,
  output logic [BYTE_W-1:0]  wr_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLICES - 1);
  localparam logic [IDX_W-1:0] DEC_IDX  = IDX_W'(1);

  phase_e            st;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shreg, rd_q, rd_sh, full_byte;
  cmd_t              cmd_q;
  logic [AW-1:0]     addr_q;
  logic              go_q, stop_q;
  logic              last, decide, fdata_rd, want_stop, want_go, enter_data, in_xfer;

  assign last      = (idx == LAST_IDX);
  assign full_byte = {shreg[BYTE_W-SLICE_W-1:0], had_i};
  assign fdata_rd  = cmd_q.fifo && cmd_q.rd && (cmd_q.nib == NIB_FDATA);
  assign decide    = ((st == ST_RETRY) || (st == ST_WAIT)) && (idx == DEC_IDX);
  assign want_stop = (st == ST_RETRY) && fdata_rd && !fifo_valid_i;
  assign want_go   = (st == ST_WAIT) || (!want_stop && (cmd_q.fifo || !stall_i));
  assign enter_data = ((st == ST_RETRY) || (st == ST_WAIT)) && last && go_q;
  assign in_xfer   = (st == ST_RETRY) || (st == ST_WAIT) || (st == ST_DATA);

  assign rdy_n_o      = !(decide && want_go);
  assign stop_o       = decide && want_stop;
  assign fifo_ready_o = enter_data && fdata_rd;
  assign had_oe_o     = cmd_q.rd && in_xfer;
  assign rd_sh        = rd_q >> (SLICE_W * int'(LAST_IDX - idx));
  assign had_o        = (st == ST_DATA && cmd_q.rd) ? rd_sh[SLICE_W-1:0] : '0;
  assign wr_en_o      = (st == ST_DATA) && last && !cmd_q.rd && !cmd_q.fifo;
  assign wr_data_o    = full_byte;
  assign cmd_o        = cmd_q;
  assign addr_o       = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      shreg  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      go_q   <= 1'b0;
      stop_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      shreg <= full_byte;
      unique case (st)
        ST_IDLE: if (ctl_i) begin
          st  <= ST_CMD;
          idx <= IDX_W'(1);
        end
        ST_CMD: begin
          idx <= idx + 1'b1;
          if (last) begin
            cmd_q <= cmd_t'(full_byte);
            if (full_byte[7:6] != DEV_CODE) st <= ST_IDLE;
            else if (full_byte[4])          st <= ST_DEC;
            else                            st <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          idx <= idx + 1'b1;
          if (last) begin
            addr_q <= full_byte[AW-1:0];
            st     <= ST_DEC;
          end
        end
        ST_DEC: begin
          st     <= ST_RETRY;
          idx    <= '0;
          go_q   <= 1'b0;
          stop_q <= 1'b0;
        end
        ST_RETRY, ST_WAIT: begin
          idx <= idx + 1'b1;
          if (decide) begin
            go_q   <= want_go;
            stop_q <= want_stop;
          end
          if (last) begin
            go_q <= 1'b0;
            if (stop_q)    st <= cmd_q.rd ? ST_TA : ST_IDLE;
            else if (go_q) begin
              st   <= ST_DATA;
              rd_q <= rd_byte_i;
            end else       st <= ST_WAIT;
          end
        end
        ST_DATA: begin
          idx <= idx + 1'b1;
          if (last) st <= cmd_q.rd ? ST_TA : ST_IDLE;
        end
        ST_TA: begin
          st  <= ST_IDLE;
          idx <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a foreign device code sends the block back to idle
  p_unsel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && last && full_byte[7:6] != DEV_CODE) |=> (st == ST_IDLE));

  // R3: one decode clock, then retry from its first slice
  p_dec_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEC) |=> (st == ST_RETRY && idx == '0));

  // R4: never more than one wait phase per byte
  p_single_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && last) |=> (st == ST_DATA));

  // R5: a stopped transfer moves no data
  p_stop_nodata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETRY && last && stop_q) |=> (st != ST_DATA));

  // R6: the FIFO is popped only while it offers a byte
  p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready_o |-> fifo_valid_i);

  // R7: turnaround releases a bus that was driven
  p_ta_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TA) |-> ($past(had_oe_o) && !had_oe_o));

  // R8: a commit comes only after a full four-slice data phase
  p_commit_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(st == ST_DATA) && $past(st == ST_DATA, 2) && $past(st == ST_DATA, 3)));
endmodule

// File: rtl/hbus2_slave.sv
`timescale 1ns/1ps
module hbus2_slave
  import hbs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NBANK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_i,
  input  logic [1:0]  had_i,
  output logic [1:0]  had_o,
  output logic        had_oe_o,
  output logic        rdy_n_o,
  output logic        stop_o,
  input  logic        stall_i,
  input  logic        fifo_valid_i,
  input  logic [7:0]  fifo_data_i,
  output logic        fifo_ready_o,
  input  logic [7:0]  fifo_stat0_i,
  input  logic [7:0]  fifo_stat1_i
);
  cmd_t              cmd;
  logic [AW-1:0]     addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_byte, reg_rd, fifo_rd;
  logic [BYTE_W-1:0] bank_rd [NBANK];

  hbs_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_i        (ctl_i),
    .had_i        (had_i),
    .stall_i      (stall_i),
    .fifo_valid_i (fifo_valid_i),
    .rd_byte_i    (rd_byte),
    .had_o        (had_o),
    .had_oe_o     (had_oe_o),
    .rdy_n_o      (rdy_n_o),
    .stop_o       (stop_o),
    .fifo_ready_o (fifo_ready_o),
    .cmd_o        (cmd),
    .addr_o       (addr),
    .wr_en_o      (wr_en),
    .wr_data_o    (wr_data)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    hbs_regbank #(.AW(AW), .DW(BYTE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_en && cmd.nib == 4'(b)),
      .addr_i  (addr),
      .wdata_i (wr_data),
      .rdata_o (bank_rd[b])
    );
  end

  always_comb begin
    reg_rd = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (cmd.nib == 4'(b)) reg_rd = bank_rd[b];
    end
    if (cmd.nib == NIB_FSTAT0)      fifo_rd = fifo_stat0_i;
    else if (cmd.nib == NIB_FSTAT1) fifo_rd = fifo_stat1_i;
    else if (cmd.nib == NIB_FDATA)  fifo_rd = fifo_data_i;
    else                            fifo_rd = '0;
    rd_byte = cmd.fifo ? fifo_rd : reg_rd;
  end
endmodule

// File: tb/hbus2_slave_tb.sv
`timescale 1ns/1ps
module hbus2_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_i = 1'b0;
  logic [1:0] had_i = 2'b00;
  logic       stall_i = 1'b0;
  logic [7:0] stat0 = 8'h5A, stat1 = 8'h03;
  logic [1:0] had_o;
  logic       had_oe_o, rdy_n_o, stop_o, fifo_ready_o;
  logic       fifo_valid_i;
  logic [7:0] fifo_data_i;

  logic [7:0] m_bank [2][256];
  logic [7:0] fq [16];
  logic [3:0] fhead = '0;
  int         fcount = 0;
  int         npops = 0;
  bit         pop_pend = 0;
  int         nchk = 0, nfail = 0;
  bit         done = 0;

  assign fifo_valid_i = (fcount != 0);
  assign fifo_data_i  = fq[fhead];

  always #5 clk = ~clk;

  hbus2_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .had_i(had_i), .had_o(had_o),
    .had_oe_o(had_oe_o), .rdy_n_o(rdy_n_o), .stop_o(stop_o), .stall_i(stall_i),
    .fifo_valid_i(fifo_valid_i), .fifo_data_i(fifo_data_i), .fifo_ready_o(fifo_ready_o),
    .fifo_stat0_i(stat0), .fifo_stat1_i(stat1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [1:0] d, input logic s);
    @(negedge clk);
    if (pop_pend) begin
      fhead++;
      fcount--;
      pop_pend = 0;
    end
    ctl_i = c; had_i = d; stall_i = s;
    #1;
    pop_pend = fifo_ready_o;
    if (fifo_ready_o) npops++;
  endtask

  task automatic push(input logic [7:0] v);
    if (fcount < 16) begin
      fq[4'(int'(fhead) + fcount)] = v;
      fcount++;
    end
  endtask

  function automatic logic [7:0] exp_rd(input bit ff, input logic [3:0] nib, input logic [7:0] adr);
    if (ff) begin
      if (nib == 4'd0) return stat0;
      if (nib == 4'd1) return stat1;
      if (nib == 4'd4) return fq[fhead];
      return 8'h00;
    end
    if (nib < 4'd2) return m_bank[nib[0]][adr];
    return 8'h00;
  endfunction

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr,
                      input logic [7:0] wd, input bit stall, output logic [7:0] rb);
    bit sel, rd, ff, estop, ewait, epop, oe_ok, q_ok;
    logic [3:0] nib;
    logic [7:0] eb;
    int pops0;
    sel = (cmd[7:6] == 2'b01); rd = cmd[5]; ff = cmd[4]; nib = cmd[3:0];
    rb = 8'h00;
    for (int i = 0; i < 4; i++) step(1'b1, cmd[7-2*i -: 2], 1'b0);
    if (!sel) begin
      q_ok = 1;
      for (int i = 0; i < 12; i++) begin
        step(1'b0, 2'($urandom), 1'b0);
        q_ok &= rdy_n_o && !stop_o && !had_oe_o && !fifo_ready_o;
      end
      chk(q_ok, "R1 unselected command stays quiet", q_ok, 1);
      return;
    end
    if (!ff) for (int i = 0; i < 4; i++) step(1'b0, adr[7-2*i -: 2], 1'b0);
    estop = ff && rd && nib == 4'd4 && fcount == 0;
    ewait = !ff && stall;
    epop  = ff && rd && nib == 4'd4 && !estop;
    eb    = exp_rd(ff, nib, adr);
    pops0 = npops;
    step(1'b0, 2'b00, stall);
    chk(rdy_n_o && !had_oe_o && !stop_o, "R3 decode clock idle", {rdy_n_o, had_oe_o, stop_o}, 3'b100);
    oe_ok = 1;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 2'b00, stall);
      oe_ok &= (had_oe_o == rd);
      if (i == 1) begin
        chk(rdy_n_o == (estop || ewait), "R3 R4 retry ready decision", rdy_n_o, estop || ewait);
        chk(stop_o == estop, "R5 stop in retry", stop_o, estop);
      end else begin
        chk(rdy_n_o && !stop_o, "R3 no decision outside second clock", {rdy_n_o, stop_o}, 2'b10);
      end
      if (i == 3 && !ewait) chk(fifo_ready_o == epop, "R6 pop strobe", fifo_ready_o, epop);
    end
    if (estop) begin
      if (rd) begin
        step(1'b0, 2'b00, 1'b0);
        chk(!had_oe_o, "R7 turnaround after stop", had_oe_o, 0);
      end
      step(1'b0, 2'b00, 1'b0);
      chk(npops == pops0, "R5 no pop on stop", npops - pops0, 0);
      return;
    end
    if (ewait) begin
      for (int i = 0; i < 4; i++) begin
        step(1'b0, 2'b00, 1'b1);
        oe_ok &= (had_oe_o == rd);
        if (i == 1) chk(!rdy_n_o, "R4 ready in wait phase", rdy_n_o, 0);
        if (i == 3) chk(!fifo_ready_o, "R4 no pop on register wait", fifo_ready_o, 0);
      end
    end
    for (int i = 0; i < 4; i++) begin
      step(1'b0, rd ? 2'b00 : wd[7-2*i -: 2], 1'b0);
      oe_ok &= (had_oe_o == rd);
      if (rd) rb = {rb[5:0], had_o};
    end
    chk(oe_ok, "R7 drive enable over retry wait data", oe_ok, 1);
    if (rd) begin
      if (ff) chk(rb == eb, "R6 FIFO read byte", rb, eb);
      else    chk(rb == eb, "R2 register read byte", rb, eb);
      step(1'b0, 2'b00, 1'b0);
      chk(!had_oe_o, "R7 turnaround release", had_oe_o, 0);
    end else if (!ff && nib < 4'd2) begin
      m_bank[nib[0]][adr] = wd;
    end
    step(1'b0, 2'b00, 1'b0);
    chk(npops == pops0 + int'(epop), "R6 pop count", npops - pops0, epop);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic [7:0] c, a;
    int r;
    void'($urandom(32'h1D5EED));
    for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) m_bank[b][i] = 8'h00;
    for (int i = 0; i < 16; i++) fq[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rdy_n_o && !stop_o && !had_oe_o && !fifo_ready_o, "R9 reset outputs",
        {rdy_n_o, stop_o, had_oe_o, fifo_ready_o}, 4'b1000);
    xfer(8'h60, 8'h37, 8'h00, 0, rb);
    chk(rb == 8'h00, "R9 register zero after reset", rb, 0);

    // Directed: bank write/readback, full byte
    xfer(8'h40, 8'hFF, 8'hC6, 0, rb);
    xfer(8'h41, 8'hFF, 8'h39, 0, rb);
    xfer(8'h60, 8'hFF, 8'h00, 0, rb);
    chk(rb == 8'hC6, "R8 full byte committed bank 0", rb, 8'hC6);
    xfer(8'h61, 8'hFF, 8'h00, 0, rb);
    chk(rb == 8'h39, "R2 general bank separate", rb, 8'h39);
    // Unused nibble: write dropped, read 0
    xfer(8'h43, 8'hFF, 8'hAA, 0, rb);
    xfer(8'h63, 8'hFF, 8'h00, 0, rb);
    chk(rb == 8'h00, "R2 unused nibble reads zero", rb, 0);
    xfer(8'h60, 8'hFF, 8'h00, 0, rb);
    chk(rb == 8'hC6, "R2 unused nibble write no effect", rb, 8'hC6);
    // Stall on register write and read
    xfer(8'h40, 8'h10, 8'h5B, 1, rb);
    xfer(8'h60, 8'h10, 8'h00, 1, rb);
    // Stall ignored on FIFO, empty FIFO data read stops
    xfer(8'h74, 8'h00, 8'h00, 1, rb);
    push(8'hE1); push(8'h2F);
    xfer(8'h74, 8'h00, 8'h00, 1, rb);
    xfer(8'h74, 8'h00, 8'h00, 0, rb);
    xfer(8'h74, 8'h00, 8'h00, 0, rb);
    xfer(8'h70, 8'h00, 8'h00, 0, rb);
    xfer(8'h71, 8'h00, 8'h00, 1, rb);
    xfer(8'h77, 8'h00, 8'h00, 0, rb);
    // Unselected commands
    xfer(8'hA0, 8'h00, 8'h00, 0, rb);
    xfer(8'h34, 8'h00, 8'h00, 0, rb);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      r = int'($urandom_range(0, 9));
      c[7:6] = (r == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      c[5]   = 1'($urandom);
      c[4]   = 1'($urandom);
      r = int'($urandom_range(0, 5));
      c[3:0] = (r < 2) ? 4'd0 : (r < 4) ? 4'd1 : (r == 4) ? 4'd4 : 4'($urandom);
      a = 8'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) push(8'($urandom));
      if ($urandom_range(0, 15) == 0) begin
        stat0 = 8'($urandom);
        stat1 = 8'($urandom);
      end
      xfer(c, a, 8'($urandom), 1'($urandom), rb);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule